// File: doc/BRIEF.md
# Shared interrupt source controller

This block collects a parameterised set of shared interrupt inputs (a multiple of eight, at most 64 with the default address layout). It conditions each one by a programmable sensing mode and delivers a request line to each of several processor contexts. Each input is sampled through a two-flop synchronizer. It can be treated as a level (active high or active low), as a single edge (rising or falling), or as a dual edge, where any transition counts. Every source has its own enable mask bit and a route register that selects exactly one context. A context's request line is high while any source routed to it is both pending and unmasked.

Software programs the block over a simple word-addressed register bus. Pending, mask and mode bits are packed 32 sources per bus word. The mask is changed only through a pair of write-one-to-set and write-one-to-clear ports, so no read-modify-write is needed. A single command register injects or removes a source's latched pending state, and this is how edge sources are acknowledged. Each source also holds a pin-map register with an enable bit and a pin number, which software can read back.

The bus has no back-pressure. A write takes effect on the clock edge at which `bus_wr` is sampled high. A read strobe returns its data registered one cycle later, qualified by `bus_rvalid`.

Top module: `sic_ctrl`

## Requirements
- R1: After reset every source is masked, level-sensitive, active-high, with dual-edge off, latched pending clear, route 0 and pin map 0. Every `ctx_irq` bit is low.
- R2: Writing word k at 0x08+k sets the mask bit of each source 32k+b whose data bit b is 1. Writing word k at 0x0C+k clears those bits. Data bits at 0 leave the mask unchanged, and the mask reads back at 0x04+k.
- R3: A level source (trigger bit 0) shows as pending when its synchronized input XOR its polarity bit is 1, or when its software latch is set. A polarity bit of 1 means active low.
- R4: An edge source (trigger bit 1, dual bit 0) latches pending on a rising input edge when its polarity bit is 0, and on a falling edge when its polarity bit is 1. The opposite edge does not set it, and it stays pending after the input returns.
- R5: An edge source with its dual bit set latches pending on both rising and falling transitions, whatever its polarity bit holds.
- R6: The command register at 0x1C takes the source number in bits [30:0]. Bit 31 equal to 1 sets that source's latched pending state, and 0 clears it. A source number of N or above changes nothing.
- R7: When a detected edge and a clear command reach the same source on the same clock edge, the source stays pending.
- R8: The route register at 0x40+i holds the context index of source i. `ctx_irq[c]` is high exactly when some source that is pending, unmasked and routed to c exists.
- R9: The pin-map register at 0x80+i holds an enable in bit 31 and a pin number in bits [PIN_W-1:0], and reads back as written.
- R10: Bit b of word k covers source 32k+b in the pending (0x00+k), mask (0x04+k), polarity (0x10+k), trigger (0x14+k) and dual (0x18+k) words. Read data appears one cycle after `bus_rd`, with `bus_rvalid` high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Raw shared interrupt inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ctx_irq | output | N_CTX | One request line per context |

## Verification
The hardest case to reach from the ports is the collision in R7, where an input edge finishes its trip through the synchronizer on the same clock edge that a clear command is written. The bench changes the input on a falling clock edge and counts two further falling edges. It then places the clear write so that it is sampled on exactly the third rising edge, which is when the latch would capture the edge. The bench expects the source to remain pending. The input-conditioning modes are walked from a vector table whose sources lie on both sides of the 32-source word boundary.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;
  localparam logic [AW-1:0] A_PEND  = 8'h00;
  localparam logic [AW-1:0] A_MASK  = 8'h04;
  localparam logic [AW-1:0] A_SMASK = 8'h08;
  localparam logic [AW-1:0] A_RMASK = 8'h0C;
  localparam logic [AW-1:0] A_POL   = 8'h10;
  localparam logic [AW-1:0] A_TRIG  = 8'h14;
  localparam logic [AW-1:0] A_DUAL  = 8'h18;
  localparam logic [AW-1:0] A_CMD   = 8'h1C;
  localparam logic [AW-1:0] A_ROUTE = 8'h40;
  localparam logic [AW-1:0] A_PIN   = 8'h80;
  localparam int unsigned CMD_SET_BIT = 31;
  localparam int unsigned PIN_EN_BIT  = 31;
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sic_src_cell.sv
module sic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic in_s,
  input  logic pol,
  input  logic trig,
  input  logic dual,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend
);
  logic prev;
  logic latch;
  logic edge_hit;

  // Single edge: rising of the polarity-corrected input; dual: any change.
  assign edge_hit = dual ? (in_s ^ prev) : ((in_s ^ pol) & ~(prev ^ pol));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      latch <= 1'b0;
    end else begin
      prev <= in_s;
      if ((edge_hit && trig) || sw_set) latch <= 1'b1;
      else if (sw_clr)                  latch <= 1'b0;
    end
  end

  assign pend = trig ? latch : ((in_s ^ pol) | latch);
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_CTX = 2,
  parameter int unsigned CW    = 1
) (
  input  logic [N_SRC-1:0]         active,
  input  logic [N_SRC-1:0][CW-1:0] route,
  output logic [N_CTX-1:0]         req
);
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic [N_SRC-1:0] hit;
    always_comb begin
      for (int i = 0; i < N_SRC; i++) hit[i] = active[i] && (route[i] == CW'(c));
    end
    assign req[c] = |hit;
  end
endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned N_SRC = 40,
  parameter int unsigned N_CTX = 2,
  parameter int unsigned PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic [N_CTX-1:0] ctx_irq
);
  localparam int unsigned NW   = (N_SRC + 31) / 32;
  localparam int unsigned NPAD = NW * 32;
  localparam int unsigned CW   = (N_CTX > 1) ? $clog2(N_CTX) : 1;

  logic [N_SRC-1:0]            src_s;
  logic [N_SRC-1:0]            mask_q, pol_q, trig_q, dual_q, pin_en_q, pend;
  logic [N_SRC-1:0][CW-1:0]    route_q;
  logic [N_SRC-1:0][PIN_W-1:0] pin_num_q;
  logic                        cmd_hit, cmd_set;
  logic [30:0]                 cmd_num;
  logic [31:0]                 rd_next;
  logic [NPAD-1:0]             pend_pad, mask_pad, pol_pad, trig_pad, dual_pad;

  sic_sync #(.W(N_SRC)) u_sync (.clk(clk), .rst_n(rst_n), .d(src_in), .q(src_s));

  assign cmd_hit = bus_wr && (bus_addr == A_CMD);
  assign cmd_set = bus_wdata[CMD_SET_BIT];
  assign cmd_num = bus_wdata[30:0];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int unsigned WI = i / 32;
    localparam int unsigned BI = i % 32;
    localparam logic [7:0] AS = 8'(A_SMASK + WI);
    localparam logic [7:0] AR = 8'(A_RMASK + WI);
    localparam logic [7:0] AP = 8'(A_POL + WI);
    localparam logic [7:0] AT = 8'(A_TRIG + WI);
    localparam logic [7:0] AD = 8'(A_DUAL + WI);
    localparam logic [7:0] AO = 8'(A_ROUTE + i);
    localparam logic [7:0] AM = 8'(A_PIN + i);
    logic sel;

    assign sel = cmd_hit && (cmd_num == 31'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[i]    <= 1'b0;
        pol_q[i]     <= 1'b0;
        trig_q[i]    <= 1'b0;
        dual_q[i]    <= 1'b0;
        route_q[i]   <= '0;
        pin_en_q[i]  <= 1'b0;
        pin_num_q[i] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == AS && bus_wdata[BI]) mask_q[i] <= 1'b1;
        if (bus_addr == AR && bus_wdata[BI]) mask_q[i] <= 1'b0;
        if (bus_addr == AP) pol_q[i]  <= bus_wdata[BI];
        if (bus_addr == AT) trig_q[i] <= bus_wdata[BI];
        if (bus_addr == AD) dual_q[i] <= bus_wdata[BI];
        if (bus_addr == AO) route_q[i] <= bus_wdata[CW-1:0];
        if (bus_addr == AM) begin
          pin_en_q[i]  <= bus_wdata[PIN_EN_BIT];
          pin_num_q[i] <= bus_wdata[PIN_W-1:0];
        end
      end
    end

    sic_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .in_s(src_s[i]),
      .pol(pol_q[i]), .trig(trig_q[i]), .dual(dual_q[i]),
      .sw_set(sel && cmd_set), .sw_clr(sel && !cmd_set),
      .pend(pend[i])
    );
  end

  sic_route #(.N_SRC(N_SRC), .N_CTX(N_CTX), .CW(CW)) u_route (
    .active(pend & mask_q), .route(route_q), .req(ctx_irq)
  );

  assign pend_pad = NPAD'(pend);
  assign mask_pad = NPAD'(mask_q);
  assign pol_pad  = NPAD'(pol_q);
  assign trig_pad = NPAD'(trig_q);
  assign dual_pad = NPAD'(dual_q);

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NW; k++) begin
      if (bus_addr == 8'(A_PEND + k)) rd_next = pend_pad[k*32 +: 32];
      if (bus_addr == 8'(A_MASK + k)) rd_next = mask_pad[k*32 +: 32];
      if (bus_addr == 8'(A_POL + k))  rd_next = pol_pad[k*32 +: 32];
      if (bus_addr == 8'(A_TRIG + k)) rd_next = trig_pad[k*32 +: 32];
      if (bus_addr == 8'(A_DUAL + k)) rd_next = dual_pad[k*32 +: 32];
    end
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == 8'(A_ROUTE + i)) rd_next = 32'(route_q[i]);
      if (bus_addr == 8'(A_PIN + i)) begin
        rd_next = 32'(pin_num_q[i]);
        rd_next[PIN_EN_BIT] = pin_en_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/sic_ctrl_chk.sv
module sic_ctrl_chk
  import sic_pkg::*;
#(
  parameter int unsigned N_SRC = 40,
  parameter int unsigned N_CTX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rvalid,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend,
  input logic [N_CTX-1:0] ctx_irq
);
  p_smask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SMASK && bus_wdata[0]) |=> mask_q[0]);

  p_rmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RMASK && bus_wdata[0]) |=> !mask_q[0]);

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_SMASK || bus_addr == A_RMASK)) |=> $stable(mask_q[0]));

  p_cmd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CMD && bus_wdata[31] && bus_wdata[30:0] == 31'd0) |=> pend[0]);

  p_no_req_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (ctx_irq == '0));

  p_req_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask_q) == '0) |-> (ctx_irq == '0));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind sic_ctrl sic_ctrl_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .mask_q(mask_q), .pend(pend), .ctx_irq(ctx_irq)
);

// File: tb/sic_ctrl_tb.sv
`timescale 1ns/1ps
module sic_ctrl_tb;
  localparam int N = 40;
  localparam int NC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] ctx_irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] pol_w [2], trig_w [2], dual_w [2];

  always #5 clk = ~clk;

  sic_ctrl #(.N_SRC(N), .N_CTX(NC), .PIN_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ctx_irq(ctx_irq)
  );

  typedef struct packed {
    logic [5:0] src;
    logic pol, trig, dual, a, b, exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 level high asserted
    '{6'd33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 level high idle
    '{6'd7,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 level low asserted
    '{6'd12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 rising edge
    '{6'd39, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 falling on rising mode
    '{6'd34, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 falling edge
    '{6'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 rising on falling mode
    '{6'd20, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 dual rise
    '{6'd31, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R5 dual fall
    '{6'd36, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}   // R5 dual, polarity ignored
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input int s, input logic p, input logic t, input logic du);
    pol_w[s/32][s%32] = p; trig_w[s/32][s%32] = t; dual_w[s/32][s%32] = du;
    wr(8'(8'h10 + s/32), pol_w[s/32]);
    wr(8'(8'h18 + s/32), dual_w[s/32]);
    wr(8'(8'h14 + s/32), trig_w[s/32]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 2; k++) begin pol_w[k] = '0; trig_w[k] = '0; dual_w[k] = '0; end
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    check(ctx_irq == '0, "R1 ctx_irq", 32'(ctx_irq), 0);
    rd(8'h04, d); check(d == 0, "R1 mask word0", d, 0);
    rd(8'h05, d); check(d == 0, "R1 mask word1", d, 0);
    rd(8'h14, d); check(d == 0, "R1 trigger word0", d, 0);
    rd(8'h00, d); check(d == 0, "R1 pending word0", d, 0);
    rd(8'h40 + 8'd35, d); check(d == 0, "R1 route", d, 0);
    rd(8'h80 + 8'd9, d); check(d == 0, "R1 pin map", d, 0);

    // Vector walk: R3 R4 R5 R8 R10
    for (int v = 0; v < 10; v++) begin
      int s; logic [31:0] bit_m;
      s = int'(VECS[v].src);
      bit_m = 32'h1 << (s % 32);
      wr(8'(8'h40 + s), 32'(s % 2));
      wr(8'(8'h08 + s/32), bit_m);
      set_mode(s, VECS[v].pol, VECS[v].trig, VECS[v].dual);
      @(negedge clk); src_in[s] = VECS[v].a;
      idle(5);
      wr(8'h1C, 32'(s));
      @(negedge clk); src_in[s] = VECS[v].b;
      idle(5);
      rd(8'(8'h00 + s/32), d);
      check(d[s%32] == VECS[v].exp, $sformatf("R10/R3-R5 vector %0d pending", v), 32'(d[s%32]), 32'(VECS[v].exp));
      check(ctx_irq[s%2] == VECS[v].exp, $sformatf("R8 vector %0d ctx", v), 32'(ctx_irq), 32'(VECS[v].exp));
      @(negedge clk); src_in[s] = 1'b0;
      idle(4);
      set_mode(s, 1'b0, 1'b0, 1'b0);
      wr(8'h1C, 32'(s));
      wr(8'(8'h0C + s/32), bit_m);
    end

    // R2 zero bits leave mask unchanged
    wr(8'h08, 32'h5); wr(8'h08, 32'h2);
    rd(8'h04, d); check(d == 32'h7, "R2 set mask", d, 32'h7);
    wr(8'h0C, 32'h1); wr(8'h0C, 32'h0);
    rd(8'h04, d); check(d == 32'h6, "R2 reset mask", d, 32'h6);
    wr(8'h0C, 32'h6);

    // R6 command set/clear on source 35, routed to context 1
    wr(8'h40 + 8'd35, 32'd1);
    wr(8'h1C, 32'h8000_0023);
    rd(8'h01, d); check(d == 32'h8, "R6 set pending", d, 32'h8);
    check(ctx_irq == 2'b00, "R8 masked no request", 32'(ctx_irq), 0);
    wr(8'h09, 32'h8);
    check(ctx_irq == 2'b10, "R8 context 1 request", 32'(ctx_irq), 32'h2);
    wr(8'h1C, 32'h0000_0023);
    rd(8'h01, d); check(d == 0, "R6 clear pending", d, 0);
    check(ctx_irq == 2'b00, "R8 request drops", 32'(ctx_irq), 0);
    wr(8'h0D, 32'h8);

    // R6 out-of-range numbers ignored
    wr(8'h1C, 32'h8000_0032);
    wr(8'h1C, 32'h8000_0040);
    rd(8'h00, d); check(d == 0, "R6 out of range word0", d, 0);
    rd(8'h01, d); check(d == 0, "R6 out of range word1", d, 0);

    // R3 software latch on a level source
    wr(8'h1C, 32'h8000_0002);
    rd(8'h00, d); check(d == 32'h4, "R3 latch on level", d, 32'h4);
    wr(8'h1C, 32'h0000_0002);

    // R7 edge and clear on the same clock edge (source 3, rising mode)
    set_mode(3, 1'b0, 1'b1, 1'b0);
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h3;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h00, d); check(d[3] == 1'b1, "R7 edge beats clear", 32'(d[3]), 1);
    wr(8'h1C, 32'h3);
    rd(8'h00, d); check(d[3] == 1'b0, "R7 later clear works", 32'(d[3]), 0);

    // R9 pin map readback
    wr(8'h80 + 8'd9, 32'h8000_0005);
    rd(8'h80 + 8'd9, d); check(d == 32'h8000_0005, "R9 pin map", d, 32'h8000_0005);
    wr(8'h40 + 8'd9, 32'd1);
    rd(8'h40 + 8'd9, d); check(d == 32'd1, "R8 route readback", d, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule